// File: doc/BRIEF.md
# Quad-Channel DAC Command Word Decoder

This block sits behind the serial front end of a four-channel DAC controller. It takes one 16-bit command word per cycle, qualified by a valid strobe, and routes it to one of three targets. The first is a global system register that holds standby, power-down and input coding. The second is one of four per-channel control registers. The third is a per-channel data register. Each channel holds a 10-bit main value and an 8-bit sub value. Every register's contents are driven out directly, so the analog side and the channel logic read them without a separate access path.

A command word is laid out as follows. Bit 15 picks main (0) or sub (1) for data words. Bits 14:13 are the route field. Bits 12:10 are the channel address. Bits 9:0 are the payload. After reset the block sits in standby with power-down asserted. Only a system-register write brings it out of standby. Data and channel-control words are still accepted while the block is in standby.

Top module: `qdac_cmd_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `standby_o`=1, `pwrdn_o`=1, `offset_bin_o`=0, `sys_o`=0x010, and every control, main and sub register reads zero.
- R2: A valid word with route 00 stores bits 9:0 in `sys_o` one cycle later. `offset_bin_o` follows sys bit 6, `standby_o` is the inverse of sys bit 5, and `pwrdn_o` follows sys bit 4. So 0x0060 gives standby 0 with offset binary, and 0x0020 gives standby 0 with two's complement.
- R3: A valid word with route 10 and address 0..3 stores bits 9:0 in that channel's control slice of `ctrl_o` (channel n at bits 10n+9:10n). For example, 0x4110 puts 0x110 in channel 0.
- R4: A valid word with route 01, bit 15 = 0 and address 0..3 stores bits 9:0 in that channel's main slice of `main_o` (bits 10n+9:10n). For example, 0x2200 loads 0x200 into channel 0.
- R5: A valid word with route 01, bit 15 = 1 and address 0..3 stores bits 9:2 of the word in that channel's sub slice of `sub_o` (bits 8n+7:8n). For example, 0xA200 loads 0x80 into channel 0.
- R6: A data or control word whose address is 4..7 changes no output.
- R7: A word with route 11 changes no output.
- R8: When `cmd_valid` is low, no output changes.
- R9: A write to one register leaves every other register unchanged, including the other data register of the same channel.
- R10: A system word is stored regardless of bit 15 and the address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word |
| sys_o | output | 10 | System register contents |
| standby_o | output | 1 | Device in standby |
| pwrdn_o | output | 1 | Power-down flag |
| offset_bin_o | output | 1 | 1 = offset binary coding, 0 = two's complement |
| ctrl_o | output | 40 | Four channel control registers, channel 0 in the low bits |
| main_o | output | 40 | Four 10-bit main data registers |
| sub_o | output | 32 | Four 8-bit sub data registers |

## Verification
The decoder is driven with system words that differ only in the coding and power bits, which tells the flag mapping apart from the raw store. Data words go to several channels with both values of the main/sub bit, so that a swapped target or a wrong sub slice shows up. Words with addresses 4 and 7 alias channels 0 and 3 when the top address bit is dropped, so an address truncation bug lands on a visible register. Route-11 words and words with the strobe low are followed by read-backs of the registers they could have hit. A mid-run reset confirms that the defaults come back.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    ROUTE_SYS  = 2'b00,
    ROUTE_DATA = 2'b01,
    ROUTE_CTRL = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  // system register flag positions
  localparam int unsigned SYS_OB_BIT   = 6;
  localparam int unsigned SYS_WAKE_BIT = 5;
  localparam int unsigned SYS_PD_BIT   = 4;
endpackage

// File: rtl/qdac_word_split.sv
module qdac_word_split
  import qdac_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PAY_W  = 10,
  localparam int unsigned WORD_W = 3 + ADDR_W + PAY_W
) (
  input  logic              vld,
  input  logic [WORD_W-1:0] word,
  output logic              sys_we,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] main_we,
  output logic [NUM_CH-1:0] sub_we,
  output logic [PAY_W-1:0]  payload
);
  localparam int unsigned ADDR_LSB  = PAY_W;
  localparam int unsigned ROUTE_LSB = PAY_W + ADDR_W;
  localparam int unsigned SEL_BIT   = WORD_W - 1;

  route_e            route;
  logic [ADDR_W-1:0] addr;
  logic              sel_sub;

  always_comb begin
    route   = route_e'(word[ROUTE_LSB +: 2]);
    addr    = word[ADDR_LSB +: ADDR_W];
    sel_sub = word[SEL_BIT];
    payload = word[PAY_W-1:0];
    sys_we  = vld && (route == ROUTE_SYS);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic hit;
    assign hit        = vld && (addr == ADDR_W'(c));
    assign ctrl_we[c] = hit && (route == ROUTE_CTRL);
    assign main_we[c] = hit && (route == ROUTE_DATA) && !sel_sub;
    assign sub_we[c]  = hit && (route == ROUTE_DATA) &&  sel_sub;
  end
endmodule

// File: rtl/qdac_sys_reg.sv
module qdac_sys_reg
  import qdac_pkg::*;
#(
  parameter int unsigned PAY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PAY_W-1:0] din,
  output logic [PAY_W-1:0] q,
  output logic             standby,
  output logic             pwrdn,
  output logic             offset_bin
);
  localparam logic [PAY_W-1:0] RST_VAL = PAY_W'(1) << SYS_PD_BIT;

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= din;
  end

  always_comb begin
    standby    = !q[SYS_WAKE_BIT];
    pwrdn      =  q[SYS_PD_BIT];
    offset_bin =  q[SYS_OB_BIT];
  end
endmodule

// File: rtl/qdac_chan_slot.sv
module qdac_chan_slot #(
  parameter int unsigned CTRL_W = 10,
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SUB_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              main_we,
  input  logic              sub_we,
  input  logic [CTRL_W-1:0] ctrl_din,
  input  logic [MAIN_W-1:0] main_din,
  input  logic [SUB_W-1:0]  sub_din,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [MAIN_W-1:0] main_q,
  output logic [SUB_W-1:0]  sub_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      main_q <= '0;
      sub_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_din;
      if (main_we) main_q <= main_din;
      if (sub_we)  sub_q  <= sub_din;
    end
  end
endmodule

// File: rtl/qdac_cmd_decoder.sv
module qdac_cmd_decoder #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SUB_W  = 8,
  localparam int unsigned WORD_W = 3 + ADDR_W + MAIN_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [WORD_W-1:0]        cmd_word,
  output logic [MAIN_W-1:0]        sys_o,
  output logic                     standby_o,
  output logic                     pwrdn_o,
  output logic                     offset_bin_o,
  output logic [NUM_CH*MAIN_W-1:0] ctrl_o,
  output logic [NUM_CH*MAIN_W-1:0] main_o,
  output logic [NUM_CH*SUB_W-1:0]  sub_o
);
  logic              sys_we;
  logic [NUM_CH-1:0] ctrl_we, main_we, sub_we;
  logic [MAIN_W-1:0] payload;

  qdac_word_split #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PAY_W(MAIN_W)) u_split (
    .vld(cmd_valid), .word(cmd_word), .sys_we(sys_we), .ctrl_we(ctrl_we),
    .main_we(main_we), .sub_we(sub_we), .payload(payload)
  );

  qdac_sys_reg #(.PAY_W(MAIN_W)) u_sys (
    .clk(clk), .rst(rst), .we(sys_we), .din(payload), .q(sys_o),
    .standby(standby_o), .pwrdn(pwrdn_o), .offset_bin(offset_bin_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qdac_chan_slot #(.CTRL_W(MAIN_W), .MAIN_W(MAIN_W), .SUB_W(SUB_W)) u_slot (
      .clk(clk), .rst(rst),
      .ctrl_we(ctrl_we[c]), .main_we(main_we[c]), .sub_we(sub_we[c]),
      .ctrl_din(payload), .main_din(payload),
      .sub_din(payload[MAIN_W-1 -: SUB_W]),
      .ctrl_q(ctrl_o[c*MAIN_W +: MAIN_W]),
      .main_q(main_o[c*MAIN_W +: MAIN_W]),
      .sub_q(sub_o[c*SUB_W +: SUB_W])
    );
  end
endmodule

// File: rtl/qdac_cmd_decoder_chk.sv
module qdac_cmd_decoder_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SUB_W  = 8,
  localparam int unsigned WORD_W = 3 + ADDR_W + MAIN_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic [WORD_W-1:0]        cmd_word,
  input logic [MAIN_W-1:0]        sys_o,
  input logic                     standby_o,
  input logic                     pwrdn_o,
  input logic                     offset_bin_o,
  input logic [NUM_CH*MAIN_W-1:0] ctrl_o,
  input logic [NUM_CH*MAIN_W-1:0] main_o,
  input logic [NUM_CH*SUB_W-1:0]  sub_o
);
  logic [1:0]        rt;
  logic [ADDR_W-1:0] ad;
  logic              ms;
  assign rt = cmd_word[MAIN_W+ADDR_W +: 2];
  assign ad = cmd_word[MAIN_W +: ADDR_W];
  assign ms = cmd_word[WORD_W-1];

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (standby_o && pwrdn_o && !offset_bin_o && ctrl_o == '0 && main_o == '0 && sub_o == '0));

  a_r2_sys_store: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rt == 2'b00) |=> sys_o == $past(cmd_word[MAIN_W-1:0]));

  a_r6_bad_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rt != 2'b00 && ad >= ADDR_W'(NUM_CH))
      |=> ($stable(ctrl_o) && $stable(main_o) && $stable(sub_o) && $stable(sys_o)));

  a_r7_rsvd_route: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rt == 2'b11)
      |=> ($stable(ctrl_o) && $stable(main_o) && $stable(sub_o) && $stable(sys_o)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(ctrl_o) && $stable(main_o) && $stable(sub_o) && $stable(sys_o)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r3_ctrl_store: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && rt == 2'b10 && ad == ADDR_W'(c))
        |=> ctrl_o[c*MAIN_W +: MAIN_W] == $past(cmd_word[MAIN_W-1:0]));
    a_r4_main_store: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && rt == 2'b01 && !ms && ad == ADDR_W'(c))
        |=> (main_o[c*MAIN_W +: MAIN_W] == $past(cmd_word[MAIN_W-1:0])
             && $stable(sub_o[c*SUB_W +: SUB_W])));
    a_r5_sub_store: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && rt == 2'b01 && ms && ad == ADDR_W'(c))
        |=> (sub_o[c*SUB_W +: SUB_W] == $past(cmd_word[MAIN_W-1 -: SUB_W])
             && $stable(main_o[c*MAIN_W +: MAIN_W])));
  end
endmodule

bind qdac_cmd_decoder qdac_cmd_decoder_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .SUB_W(SUB_W)
) i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .sys_o(sys_o), .standby_o(standby_o), .pwrdn_o(pwrdn_o),
  .offset_bin_o(offset_bin_o), .ctrl_o(ctrl_o), .main_o(main_o), .sub_o(sub_o)
);

// File: tb/test_qdac_cmd_decoder.sv
module test_qdac_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic [9:0]  sys_o;
  logic        standby_o, pwrdn_o, offset_bin_o;
  logic [39:0] ctrl_o, main_o;
  logic [31:0] sub_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  qdac_cmd_decoder i_qdac_cmd_decoder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .sys_o(sys_o), .standby_o(standby_o), .pwrdn_o(pwrdn_o),
    .offset_bin_o(offset_bin_o), .ctrl_o(ctrl_o), .main_o(main_o), .sub_o(sub_o)
  );

  // sel: 0 sys, 1 ctrl[ch], 2 main[ch], 3 sub[ch], 4 {offset,pwrdn,standby}
  typedef struct packed {
    logic        vld;
    logic [15:0] w;
    logic [2:0]  sel;
    logic [1:0]  ch;
    logic [9:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0060, 3'd0, 2'd0, 10'h060, 4'd2},  // R2 offset binary wake
    '{1'b0, 16'h0000, 3'd4, 2'd0, 10'h004, 4'd2},  // R2 flags {ob=1,pd=0,sb=0}
    '{1'b1, 16'h0020, 3'd0, 2'd0, 10'h020, 4'd2},  // R2 two's complement wake
    '{1'b0, 16'h0000, 3'd4, 2'd0, 10'h000, 4'd2},  // R2 flags all clear
    '{1'b1, 16'h4110, 3'd1, 2'd0, 10'h110, 4'd3},  // R3 channel 0 control
    '{1'b1, 16'h47FF, 3'd1, 2'd1, 10'h3FF, 4'd3},  // R3 channel 1 control
    '{1'b1, 16'h2200, 3'd2, 2'd0, 10'h200, 4'd4},  // R4 half scale ch0
    '{1'b1, 16'h2FFF, 3'd2, 2'd3, 10'h3FF, 4'd4},  // R4 full scale ch3
    '{1'b1, 16'hA200, 3'd3, 2'd0, 10'h080, 4'd5},  // R5 sub ch0
    '{1'b1, 16'hA955, 3'd3, 2'd2, 10'h055, 4'd5},  // R5 sub ch2 top bits
    '{1'b0, 16'h0000, 3'd2, 2'd0, 10'h200, 4'd9},  // R9 main ch0 kept after sub write
    '{1'b0, 16'h0000, 3'd1, 2'd0, 10'h110, 4'd9},  // R9 ch0 control kept
    '{1'b1, 16'h3123, 3'd2, 2'd0, 10'h200, 4'd6},  // R6 addr 4 data ignored
    '{1'b1, 16'h5C01, 3'd1, 2'd3, 10'h000, 4'd6},  // R6 addr 7 control ignored
    '{1'b1, 16'h60AB, 3'd0, 2'd0, 10'h020, 4'd7},  // R7 route 11 not system
    '{1'b1, 16'h60AB, 3'd1, 2'd0, 10'h110, 4'd7},  // R7 route 11 not control
    '{1'b0, 16'h23FF, 3'd2, 2'd0, 10'h200, 4'd8},  // R8 strobe low ignored
    '{1'b1, 16'h9C50, 3'd0, 2'd0, 10'h050, 4'd10}, // R10 junk bits on system word
    '{1'b0, 16'h0000, 3'd4, 2'd0, 10'h007, 4'd10}  // R10 flags {1,1,1}
  };

  function automatic logic [9:0] pick(input logic [2:0] sel, input logic [1:0] ch);
    case (sel)
      3'd0:    return sys_o;
      3'd1:    return ctrl_o[ch*10 +: 10];
      3'd2:    return main_o[ch*10 +: 10];
      3'd3:    return {2'b00, sub_o[ch*8 +: 8]};
      default: return {7'd0, offset_bin_o, pwrdn_o, standby_o};
    endcase
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check(tag, {38'd0, sys_o}, 48'h010);
    check(tag, {45'd0, offset_bin_o, pwrdn_o, standby_o}, 48'h3);
    check(tag, {8'd0, ctrl_o}, 48'h0);
    check(tag, {8'd0, main_o}, 48'h0);
    check(tag, {16'd0, sub_o}, 48'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1 during reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_reset_state("R1 after release");

    for (int i = 0; i < NV; i++) begin
      cmd_valid = VEC[i].vld;
      cmd_word  = VEC[i].w;
      @(posedge clk); @(negedge clk);
      cmd_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            {38'd0, pick(VEC[i].sel, VEC[i].ch)}, {38'd0, VEC[i].exp});
    end

    // R9: full image of all channels after the table
    check("R9 ctrl image", {8'd0, ctrl_o}, {8'd0, 10'h000, 10'h000, 10'h3FF, 10'h110});
    check("R9 main image", {8'd0, main_o}, {8'd0, 10'h3FF, 10'h000, 10'h000, 10'h200});
    check("R9 sub image",  {16'd0, sub_o}, {16'd0, 8'h00, 8'h55, 8'h00, 8'h80});

    // R5: sub write with all-ones payload keeps only 8 bits
    cmd_valid = 1'b1; cmd_word = 16'hA7FF;  // ch1 sub
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check("R5 sub ch1 all ones", {40'd0, sub_o[15:8]}, 48'hFF);
    check("R9 main ch1 untouched", {38'd0, main_o[19:10]}, 48'h0);

    // R1: mid-run reset restores defaults
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check_reset_state("R1 mid-run reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule